// File: doc/BRIEF.md
# Integer ALU with Set-Compare Operations

This block is the combinational execute unit of a small load/store integer core. It takes a primary opcode, a function field, two 32-bit register values and a 16-bit immediate. It returns one 32-bit result and an illegal-operation flag. It supports addition, subtraction, the three bitwise logic operations, the three shifts, and four compare operations whose result is 1 or 0.

When the primary opcode is zero, the instruction is in register-register form. The function field then picks the operation and the second register supplies operand B. Any other primary opcode selects an immediate form. In that case the opcode alone picks the operation, and operand B comes from the immediate. The immediate is sign-extended for arithmetic and compares and zero-extended for the logic operations. Each immediate opcode maps to the same operation as its register counterpart. The block has no registers and no clock, and it raises no trap on overflow.

Top module: `int_alu`

## Requirements
- R1: In register form (op_major = 0x00), function 0x20 gives src_a + src_b and function 0x22 gives src_a - src_b, both modulo 2^32.
- R2: In register form, function 0x24 gives bitwise AND, 0x25 gives OR and 0x26 gives XOR of src_a and src_b.
- R3: In register form, function 0x04 shifts src_a left, 0x06 shifts it right filling with zeros, and 0x07 shifts it right copying bit 31. The shift amount is src_b[4:0].
- R4: In register form, functions 0x28 (equal), 0x29 (not equal), 0x2a (signed less-than) and 0x2c (signed less-or-equal) return 32'd1 when the condition holds and 32'd0 otherwise.
- R5: When op_major is nonzero, it selects the operation. The mapping is 0x08 add, 0x0a sub, 0x0c and, 0x0d or, 0x0e xor, 0x14 sll, 0x16 srl, 0x17 sra, 0x18 equal, 0x19 not-equal, 0x1a less-than, 0x1c less-or-equal.
- R6: For immediate add, sub and the four immediate compares, operand B is imm sign-extended to 32 bits.
- R7: For the immediate and, or and xor, operand B is imm zero-extended. For the immediate shifts, the shift amount is imm[4:0].
- R8: Any unlisted primary opcode, and any unlisted function code in register form, drives result to 0 and illegal to 1. Every listed operation drives illegal to 0.
- R9: In immediate form, src_b has no effect on result. In register form, neither imm nor op_func bits outside the selected code have any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_major | input | 6 | Primary opcode; 0 selects register form |
| op_func | input | 6 | Function field used in register form |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field used in immediate form |
| result | output | 32 | Operation result |
| illegal | output | 1 | High when the operation code is not recognised |

## Verification
The hardest cases to reach are the signed compares where the two operands have opposite signs. The subtraction overflows there, and its sign bit gives the wrong order. The bench drives extreme pairs such as 0x80000000 against 0x7fffffff and -1 against 0. It also drives a negative immediate against a positive register, in both register and immediate form. To show that an ignored input has no effect, the bench applies the same operation twice with only the ignored field changed and requires the same result.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32,
  parameter int IW = 16
) (
  input  logic [5:0]    op_major,
  input  logic [5:0]    op_func,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  result,
  output logic          illegal
);
  localparam int SW = $clog2(W);

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_SLL, K_SRL, K_SRA,
    K_SEQ, K_SNE, K_SLT, K_SLE, K_BAD
  } kind_t;

  kind_t kind;
  logic  imm_form;
  logic  zext;

  assign imm_form = (op_major != 6'h00);

  always_comb begin
    kind = K_BAD;
    zext = 1'b0;
    if (!imm_form) begin
      case (op_func)
        6'h20: kind = K_ADD;
        6'h22: kind = K_SUB;
        6'h24: kind = K_AND;
        6'h25: kind = K_OR;
        6'h26: kind = K_XOR;
        6'h04: kind = K_SLL;
        6'h06: kind = K_SRL;
        6'h07: kind = K_SRA;
        6'h28: kind = K_SEQ;
        6'h29: kind = K_SNE;
        6'h2a: kind = K_SLT;
        6'h2c: kind = K_SLE;
        default: kind = K_BAD;
      endcase
    end else begin
      case (op_major)
        6'h08: kind = K_ADD;
        6'h0a: kind = K_SUB;
        6'h0c: begin kind = K_AND; zext = 1'b1; end
        6'h0d: begin kind = K_OR;  zext = 1'b1; end
        6'h0e: begin kind = K_XOR; zext = 1'b1; end
        6'h14: kind = K_SLL;
        6'h16: kind = K_SRL;
        6'h17: kind = K_SRA;
        6'h18: kind = K_SEQ;
        6'h19: kind = K_SNE;
        6'h1a: kind = K_SLT;
        6'h1c: kind = K_SLE;
        default: kind = K_BAD;
      endcase
    end
  end

  logic [W-1:0] opb;
  assign opb = !imm_form ? src_b :
               zext      ? {{(W-IW){1'b0}}, imm} :
                           {{(W-IW){imm[IW-1]}}, imm};

  logic          do_sub;
  logic [W-1:0]  sum;
  logic          eq, lt;
  logic [SW-1:0] sh;

  assign do_sub = (kind != K_ADD);
  assign sum    = src_a + (do_sub ? ~opb : opb) + {{(W-1){1'b0}}, do_sub};
  assign eq     = (src_a == opb);
  assign lt     = (src_a[W-1] != opb[W-1]) ? src_a[W-1] : sum[W-1];
  assign sh     = opb[SW-1:0];

  always_comb begin
    result = '0;
    case (kind)
      K_ADD, K_SUB: result = sum;
      K_AND: result = src_a & opb;
      K_OR:  result = src_a | opb;
      K_XOR: result = src_a ^ opb;
      K_SLL: result = src_a << sh;
      K_SRL: result = src_a >> sh;
      K_SRA: result = W'($signed(src_a) >>> sh);
      K_SEQ: result = {{(W-1){1'b0}}, eq};
      K_SNE: result = {{(W-1){1'b0}}, !eq};
      K_SLT: result = {{(W-1){1'b0}}, lt};
      K_SLE: result = {{(W-1){1'b0}}, lt | eq};
      default: result = '0;
    endcase
  end

  assign illegal = (kind == K_BAD);
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk (
  input logic [5:0]  op_major,
  input logic [5:0]  op_func,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [15:0] imm,
  input logic [31:0] result,
  input logic        illegal
);
  logic reg_form;
  logic reg_cmp;
  assign reg_form = (op_major == 6'h00);
  assign reg_cmp  = reg_form && (op_func == 6'h28 || op_func == 6'h29 ||
                                 op_func == 6'h2a || op_func == 6'h2c);

  always @* begin
    if (illegal)
      p_illegal_zero_r8: assert (result == 32'd0) else $error("illegal with nonzero result");
    if (reg_cmp)
      p_set_bool_r4: assert (result[31:1] == 31'd0 && !illegal) else $error("compare not 0/1");
    if (reg_form && op_func == 6'h28)
      p_seq_match_r4: assert (result[0] == (src_a == src_b)) else $error("seq mismatch");
    if (reg_form && op_func == 6'h20)
      p_add_wrap_r1: assert (result == src_a + src_b) else $error("add mismatch");
    if (op_major == 6'h08)
      p_addi_sext_r6: assert (result == src_a + {{16{imm[15]}}, imm}) else $error("addi mismatch");
    if (op_major == 6'h0c)
      p_andi_zext_r7: assert (result[31:16] == 16'd0) else $error("andi high bits set");
    if (op_major == 6'h1a || op_major == 6'h08)
      p_known_legal_r5: assert (!illegal) else $error("listed opcode flagged");
  end
endmodule

bind int_alu int_alu_chk u_chk (.*);

// File: tb/test_int_alu.sv
module test_int_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  op_major, op_func;
  logic [31:0] src_a, src_b;
  logic [15:0] imm;
  logic [31:0] result;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;

  int_alu i_int_alu (
    .op_major(op_major), .op_func(op_func), .src_a(src_a), .src_b(src_b),
    .imm(imm), .result(result), .illegal(illegal)
  );

  task automatic apply(input logic [5:0] mj, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
    @(negedge clk);
    op_major = mj; op_func = fn; src_a = a; src_b = b; imm = im;
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] exp_r, input logic exp_i);
    n_cmp++;
    if (result !== exp_r || illegal !== exp_i) begin
      n_bad++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result, illegal, exp_r, exp_i);
    end
  endtask

  task automatic t_reset;
    apply(6'h00, 6'h00, 32'h0, 32'h0, 16'h0);
    chk("R8 reset/all-zero", 32'h0, 1'b1);
  endtask

  task automatic t_arith;
    apply(6'h00, 6'h20, 32'hffff_ffff, 32'h0000_0002, 16'h0); chk("R1 add wrap", 32'h1, 0);
    apply(6'h00, 6'h20, 32'h1234_0000, 32'h0000_5678, 16'h0); chk("R1 add", 32'h1234_5678, 0);
    apply(6'h00, 6'h22, 32'h0000_0003, 32'h0000_0005, 16'h0); chk("R1 sub wrap", 32'hffff_fffe, 0);
    apply(6'h00, 6'h22, 32'h8000_0000, 32'h0000_0001, 16'h0); chk("R1 sub", 32'h7fff_ffff, 0);
  endtask

  task automatic t_logic;
    apply(6'h00, 6'h24, 32'hf0f0_ff00, 32'h3c3c_0ff0, 16'h0); chk("R2 and", 32'h3030_0f00, 0);
    apply(6'h00, 6'h25, 32'hf0f0_ff00, 32'h3c3c_0ff0, 16'h0); chk("R2 or",  32'hfcfc_fff0, 0);
    apply(6'h00, 6'h26, 32'hf0f0_ff00, 32'h3c3c_0ff0, 16'h0); chk("R2 xor", 32'hcccc_f0f0, 0);
  endtask

  task automatic t_shift;
    apply(6'h00, 6'h04, 32'h8000_0001, 32'h0000_0021, 16'h0); chk("R3 sll amt low5", 32'h0000_0002, 0);
    apply(6'h00, 6'h04, 32'h0000_0001, 32'h0000_001f, 16'h0); chk("R3 sll 31", 32'h8000_0000, 0);
    apply(6'h00, 6'h06, 32'h8000_0000, 32'h0000_0004, 16'h0); chk("R3 srl", 32'h0800_0000, 0);
    apply(6'h00, 6'h07, 32'h8000_0000, 32'h0000_0004, 16'h0); chk("R3 sra neg", 32'hf800_0000, 0);
    apply(6'h00, 6'h07, 32'h4000_0000, 32'h0000_001e, 16'h0); chk("R3 sra pos", 32'h0000_0001, 0);
    apply(6'h00, 6'h07, 32'h8765_4321, 32'h0000_0000, 16'h0); chk("R3 sra zero amt", 32'h8765_4321, 0);
  endtask

  task automatic t_compare;
    apply(6'h00, 6'h28, 32'h5, 32'h5, 16'h0); chk("R4 seq true", 32'h1, 0);
    apply(6'h00, 6'h28, 32'h5, 32'h6, 16'h0); chk("R4 seq false", 32'h0, 0);
    apply(6'h00, 6'h29, 32'h5, 32'h6, 16'h0); chk("R4 sne true", 32'h1, 0);
    apply(6'h00, 6'h29, 32'h7, 32'h7, 16'h0); chk("R4 sne false", 32'h0, 0);
    apply(6'h00, 6'h2a, 32'h8000_0000, 32'h7fff_ffff, 16'h0); chk("R4 slt min<max", 32'h1, 0);
    apply(6'h00, 6'h2a, 32'h7fff_ffff, 32'h8000_0000, 16'h0); chk("R4 slt max<min", 32'h0, 0);
    apply(6'h00, 6'h2a, 32'hffff_ffff, 32'h0, 16'h0); chk("R4 slt -1<0", 32'h1, 0);
    apply(6'h00, 6'h2a, 32'h3, 32'h3, 16'h0); chk("R4 slt equal", 32'h0, 0);
    apply(6'h00, 6'h2c, 32'h3, 32'h3, 16'h0); chk("R4 sle equal", 32'h1, 0);
    apply(6'h00, 6'h2c, 32'h0, 32'hffff_ffff, 16'h0); chk("R4 sle 0<=-1", 32'h0, 0);
  endtask

  task automatic t_imm_map;
    apply(6'h14, 6'h00, 32'h0000_0003, 32'h0, 16'h0004); chk("R5 slli", 32'h0000_0030, 0);
    apply(6'h16, 6'h00, 32'hf000_0000, 32'h0, 16'h0004); chk("R5 srli", 32'h0f00_0000, 0);
    apply(6'h17, 6'h00, 32'hf000_0000, 32'h0, 16'h0024); chk("R7 srai imm low5", 32'hff00_0000, 0);
    apply(6'h0d, 6'h00, 32'h0001_0000, 32'h0, 16'h8001); chk("R7 ori zext", 32'h0001_8001, 0);
    apply(6'h0c, 6'h00, 32'hffff_ffff, 32'h0, 16'hf00f); chk("R7 andi zext", 32'h0000_f00f, 0);
    apply(6'h0e, 6'h00, 32'hffff_0000, 32'h0, 16'hffff); chk("R7 xori zext", 32'hffff_ffff, 0);
  endtask

  task automatic t_imm_sext;
    apply(6'h08, 6'h00, 32'h0000_0010, 32'h0, 16'hfffe); chk("R6 addi neg", 32'h0000_000e, 0);
    apply(6'h0a, 6'h00, 32'h0000_0000, 32'h0, 16'hffff); chk("R6 subi neg", 32'h0000_0001, 0);
    apply(6'h18, 6'h00, 32'hffff_8000, 32'h0, 16'h8000); chk("R6 seqi sext", 32'h1, 0);
    apply(6'h19, 6'h00, 32'h0000_8000, 32'h0, 16'h8000); chk("R6 snei sext", 32'h1, 0);
    apply(6'h1a, 6'h00, 32'h0000_0001, 32'h0, 16'hffff); chk("R6 slti 1<-1", 32'h0, 0);
    apply(6'h1c, 6'h00, 32'hffff_fff0, 32'h0, 16'hfff0); chk("R6 slei equal neg", 32'h1, 0);
  endtask

  task automatic t_illegal;
    apply(6'h00, 6'h21, 32'h1, 32'h1, 16'h0); chk("R8 bad func", 32'h0, 1);
    apply(6'h00, 6'h3f, 32'hffff_ffff, 32'hffff_ffff, 16'h0); chk("R8 bad func 3f", 32'h0, 1);
    apply(6'h09, 6'h20, 32'h1, 32'h1, 16'h1); chk("R8 bad opcode", 32'h0, 1);
    apply(6'h3f, 6'h20, 32'h1, 32'h1, 16'h1); chk("R8 bad opcode 3f", 32'h0, 1);
  endtask

  task automatic t_ignore;
    apply(6'h08, 6'h00, 32'h100, 32'hdead_beef, 16'h0001); chk("R9 src_b ignored imm form", 32'h101, 0);
    apply(6'h08, 6'h00, 32'h100, 32'h0000_0000, 16'h0001); chk("R9 src_b ignored imm form", 32'h101, 0);
    apply(6'h00, 6'h20, 32'h100, 32'h0000_0002, 16'hffff); chk("R9 imm ignored reg form", 32'h102, 0);
    apply(6'h0c, 6'h3f, 32'h0000_00ff, 32'hffff_ffff, 16'h000f); chk("R9 func ignored imm form", 32'h0000_000f, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    op_major = '0; op_func = '0; src_a = '0; src_b = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arith();
    t_logic();
    t_shift();
    t_compare();
    t_imm_map();
    t_imm_sext();
    t_illegal();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule